// File: doc/BRIEF.md
# Core-Local Prioritized Interrupt Controller

This block sits beside one processor core and collects a parameterized number of interrupt lines. Each line has its own pending bit, enable bit, trigger mode (level, rising edge or falling edge) and an 8-bit control byte. A global field divides that byte into a level part and a priority part. Among the enabled pending lines the controller picks one winner and offers it to the core as a request with a source id and a level. A request is passed on only if the winner's level is above a software threshold and strictly above the level of the handler that is running now.

The core handshake works like valid/ready. `irq_req` is valid and `irq_ack` is ready, and a transfer takes place in a cycle where both are high. The offered id and level are not held while the core waits: a stronger candidate that arrives before the acknowledge replaces them. The acknowledge always takes the values offered in its own cycle. An acknowledge pushes the taken level onto a small stack of active levels, and `irq_ret` pops it. A lower-level interrupt that is still pending is offered in the cycle right after the return, so the core can chain straight into it without restoring and saving context again. Software reaches all state through a plain register bus: combinational reads and single-cycle writes.

Top module: `irqc`

## Requirements
- R1: After reset, `irq_req` is 0. Every source reads pending 0, enable 0 and trigger level, with its control byte showing only the unimplemented low bits as ones (0x0F for 4 implemented bits). The configuration and threshold registers read 0.
- R2: Address bit IDW selects the source area; source i sits at address NSRC+i in the area, with the word holding pending in [0], enable in [1], trigger in [3:2] and control in [15:8]. Global address 0 is the configuration register (level-bit count in [3:0]), 1 is a read-only information word {version[31:24], implemented control bits[23:20], 0[19:16], NSRC[15:0]}, and 2 is the threshold register [7:0].
- R3: Trigger code 0 (and 3) is level mode. In level mode the pending bit takes the value of the input one clock later, and software writes to the pending bit have no effect.
- R4: Trigger code 1 sets pending on a 0-to-1 input change and code 2 sets it on a 1-to-0 change. In these edge modes, pending is cleared by writing 0 to it or by the core acknowledging that source. It stays clear while the input is held steady.
- R5: Unimplemented low control bits read as ones. With n level bits, the level is the control byte with its low 8-n bits forced to one. The priority is the control byte shifted left by n, with its low n bits forced to one.
- R6: The winner is the enabled pending source with the highest level. A tie in level goes to the highest priority, and a remaining tie goes to the highest source id.
- R7: No request is made unless the winner's level is strictly greater than the threshold.
- R8: While a handler is active, a request is made only for a level strictly greater than the top of the active-level stack.
- R9: An acknowledge while `irq_req` is high pushes `irq_lvl`, and `irq_ret` pops one entry. After a return, a pending interrupt above the new top level is requested in the next cycle (tail-chaining).
- R10: While the stack holds DEPTH entries, no request is made.
- R11: A disabled source is never requested, although its pending bit still tracks its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Raw interrupt source lines, synchronous to clk |
| bus_addr | input | IDW+1 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the core (valid) |
| irq_id | output | IDW | Source id of the offered interrupt |
| irq_lvl | output | 8 | Level of the offered interrupt |
| irq_ack | input | 1 | Core takes the offered interrupt (ready) |
| irq_ret | input | 1 | Core returns from the current handler |

## Verification
The bench builds the block with NSRC=8, four implemented control bits and a stack DEPTH of 2. With a depth of two, the stack fills after just one preemption, so the full-stack masking and the unwinding through two returns are both exercised. Four implemented bits make the fill-with-ones behaviour of the low control bits visible. They also allow the level/priority split to be moved from four level bits to two, so the same control bytes compare differently under each split.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned CTLW  = 8;
  localparam int unsigned WORDW = 32;

  typedef enum logic [1:0] {
    TRG_LEVEL = 2'd0,
    TRG_RISE  = 2'd1,
    TRG_FALL  = 2'd2,
    TRG_LVL2  = 2'd3
  } trig_e;

  typedef struct packed {
    logic [CTLW-1:0] lvl;
    logic [CTLW-1:0] prio;
  } key_t;
endpackage

// File: rtl/irqc_src.sv
module irqc_src
  import irqc_pkg::*;
#(
  parameter int unsigned CTL_BITS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_i,
  input  logic [3:0]      nl_i,
  input  logic            wr_i,
  input  logic            wpend_i,
  input  logic            wen_i,
  input  trig_e           wtrig_i,
  input  logic [CTLW-1:0] wctl_i,
  input  logic            ack_i,
  output logic            pend_o,
  output logic            en_o,
  output trig_e           trig_o,
  output logic [CTLW-1:0] ctl_o,
  output key_t            key_o
);
  localparam logic [CTLW-1:0] FILL = 8'hFF >> CTL_BITS;

  logic prev_q;
  logic edge_hit;
  logic lvl_mode;

  assign lvl_mode = (trig_o != TRG_RISE) && (trig_o != TRG_FALL);
  assign edge_hit = ((trig_o == TRG_RISE) && src_i && !prev_q) ||
                    ((trig_o == TRG_FALL) && !src_i && prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
      en_o   <= 1'b0;
      trig_o <= TRG_LEVEL;
      ctl_o  <= FILL;
    end else begin
      prev_q <= src_i;
      if (lvl_mode)      pend_o <= src_i;
      else if (edge_hit) pend_o <= 1'b1;
      else if (ack_i)    pend_o <= 1'b0;
      else if (wr_i)     pend_o <= wpend_i;
      if (wr_i) begin
        en_o   <= wen_i;
        trig_o <= wtrig_i;
        ctl_o  <= wctl_i | FILL;
      end
    end
  end

  always_comb begin
    key_o.lvl  = ctl_o | (8'hFF >> nl_i);
    key_o.prio = (ctl_o << nl_i) | ~(8'hFF << nl_i);
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 16,
  parameter int unsigned IDW  = 4
) (
  input  logic [NSRC-1:0] cand_i,
  input  key_t            key_i [NSRC],
  output logic            found_o,
  output logic [IDW-1:0]  id_o,
  output logic [CTLW-1:0] lvl_o
);
  key_t best;

  always_comb begin
    found_o = 1'b0;
    best    = '0;
    id_o    = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (cand_i[k] && (!found_o || key_i[k] >= best)) begin
        found_o = 1'b1;
        best    = key_i[k];
        id_o    = IDW'(k);
      end
    end
    lvl_o = best.lvl;
  end
endmodule

// File: rtl/irqc_stack.sv
module irqc_stack
  import irqc_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SPW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [CTLW-1:0] lvl_i,
  output logic [CTLW-1:0] act_o,
  output logic            full_o,
  output logic [SPW-1:0]  sp_o
);
  logic [CTLW-1:0] stk [DEPTH];

  assign full_o = (int'(sp_o) == DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_o <= '0;
      for (int k = 0; k < DEPTH; k++) stk[k] <= '0;
    end else if (push_i && pop_i && sp_o != '0) begin
      for (int k = 0; k < DEPTH; k++)
        if (k + 1 == int'(sp_o)) stk[k] <= lvl_i;
    end else if (push_i && !full_o) begin
      for (int k = 0; k < DEPTH; k++)
        if (k == int'(sp_o)) stk[k] <= lvl_i;
      sp_o <= sp_o + SPW'(1);
    end else if (pop_i && sp_o != '0) begin
      sp_o <= sp_o - SPW'(1);
    end
  end

  always_comb begin
    act_o = '0;
    for (int k = 0; k < DEPTH; k++)
      if (k + 1 == int'(sp_o)) act_o = stk[k];
  end
endmodule

// File: rtl/irqc.sv
module irqc
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC     = 16,
  parameter int unsigned CTL_BITS = 4,
  parameter int unsigned DEPTH    = 4,
  parameter logic [7:0]  VERSION  = 8'h01,
  localparam int unsigned IDW     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic [IDW:0]     bus_addr,
  input  logic             bus_we,
  input  logic [WORDW-1:0] bus_wdata,
  output logic [WORDW-1:0] bus_rdata,
  output logic             irq_req,
  output logic [IDW-1:0]   irq_id,
  output logic [CTLW-1:0]  irq_lvl,
  input  logic             irq_ack,
  input  logic             irq_ret
);
  localparam int unsigned SPW = $clog2(DEPTH + 1);
  localparam logic [WORDW-1:0] INFO = {VERSION, 4'(CTL_BITS), 4'b0, 16'(NSRC)};

  logic [3:0]      nl_q;
  logic [CTLW-1:0] thr_q;
  logic [IDW-1:0]  idx;
  logic            sel_src;
  logic            ack_ok;
  logic [NSRC-1:0] pend_v, en_v, lvlmode_v;
  trig_e           trig_v [NSRC];
  logic [CTLW-1:0] ctl_v  [NSRC];
  key_t            key_v  [NSRC];
  logic            found;
  logic [IDW-1:0]  win_id;
  logic [CTLW-1:0] win_lvl, act_lvl;
  logic            stk_full;
  logic [SPW-1:0]  stk_sp;
  logic            unused_wbits;

  assign unused_wbits = ^{bus_wdata[31:16], bus_wdata[7:4]};
  assign idx     = bus_addr[IDW-1:0];
  assign sel_src = bus_addr[IDW];
  assign ack_ok  = irq_ack && irq_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nl_q  <= '0;
      thr_q <= '0;
    end else if (bus_we && !sel_src) begin
      if (idx == IDW'(0)) nl_q  <= bus_wdata[3:0];
      if (idx == IDW'(2)) thr_q <= bus_wdata[7:0];
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irqc_src #(.CTL_BITS(CTL_BITS)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i[g]),
      .nl_i   (nl_q),
      .wr_i   (bus_we && sel_src && idx == IDW'(g)),
      .wpend_i(bus_wdata[0]),
      .wen_i  (bus_wdata[1]),
      .wtrig_i(trig_e'(bus_wdata[3:2])),
      .wctl_i (bus_wdata[15:8]),
      .ack_i  (ack_ok && irq_id == IDW'(g)),
      .pend_o (pend_v[g]),
      .en_o   (en_v[g]),
      .trig_o (trig_v[g]),
      .ctl_o  (ctl_v[g]),
      .key_o  (key_v[g])
    );
    assign lvlmode_v[g] = (trig_v[g] != TRG_RISE) && (trig_v[g] != TRG_FALL);
  end

  irqc_arb #(.NSRC(NSRC), .IDW(IDW)) u_arb (
    .cand_i (pend_v & en_v),
    .key_i  (key_v),
    .found_o(found),
    .id_o   (win_id),
    .lvl_o  (win_lvl)
  );

  irqc_stack #(.DEPTH(DEPTH), .SPW(SPW)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push_i(ack_ok),
    .pop_i (irq_ret),
    .lvl_i (irq_lvl),
    .act_o (act_lvl),
    .full_o(stk_full),
    .sp_o  (stk_sp)
  );

  assign irq_req = found && (win_lvl > thr_q) && (win_lvl > act_lvl) && !stk_full;
  assign irq_id  = win_id;
  assign irq_lvl = win_lvl;

  always_comb begin
    bus_rdata = '0;
    if (sel_src) begin
      for (int k = 0; k < NSRC; k++)
        if (idx == IDW'(k))
          bus_rdata = {16'b0, ctl_v[k], 4'b0, trig_v[k], en_v[k], pend_v[k]};
    end else if (idx == IDW'(0)) begin
      bus_rdata = {28'b0, nl_q};
    end else if (idx == IDW'(1)) begin
      bus_rdata = INFO;
    end else if (idx == IDW'(2)) begin
      bus_rdata = {24'b0, thr_q};
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NSRC  = 16,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SPW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_req,
  input logic [7:0]      irq_lvl,
  input logic            irq_ack,
  input logic            irq_ret,
  input logic [7:0]      thr,
  input logic [7:0]      act,
  input logic [SPW-1:0]  sp,
  input logic            full,
  input logic [NSRC-1:0] src_i,
  input logic [NSRC-1:0] pend_v,
  input logic [NSRC-1:0] lvlmode_v
);
  assert_req_above_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_lvl > thr);

  assert_preempt_strict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_lvl > act);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sp) <= DEPTH);

  assert_no_req_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !full);

  assert_push_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> act == $past(irq_lvl));

  assert_pop_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack && sp != '0) |=> int'(sp) == int'($past(sp)) - 1);

  assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_v ^ $past(src_i)) & $past(lvlmode_v)) == '0);
endmodule

bind irqc irqc_chk #(.NSRC(NSRC), .DEPTH(DEPTH), .SPW(SPW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_req  (irq_req),
  .irq_lvl  (irq_lvl),
  .irq_ack  (irq_ack),
  .irq_ret  (irq_ret),
  .thr      (thr_q),
  .act      (act_lvl),
  .sp       (stk_sp),
  .full     (stk_full),
  .src_i    (src_i),
  .pend_v   (pend_v),
  .lvlmode_v(lvlmode_v)
);

// File: tb/sim_irqc.sv
module sim_irqc;
  localparam int NSRC = 8;
  localparam int IDW  = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic [IDW:0]    bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            irq_req;
  logic [IDW-1:0]  irq_id;
  logic [7:0]      irq_lvl;
  logic            irq_ack = 1'b0;
  logic            irq_ret = 1'b0;

  always #5 clk = ~clk;

  irqc #(.NSRC(NSRC), .CTL_BITS(4), .DEPTH(2), .VERSION(8'h01)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_id(irq_id),
    .irq_lvl(irq_lvl), .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  typedef struct {
    string      tag;
    logic       req;
    logic [2:0] id;
    logic [7:0] lvl;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  // monitor: compares the core-side outputs against queued expectations
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (irq_req !== e.req || (e.req && (irq_id !== e.id || irq_lvl !== e.lvl))) begin
        fails++;
        $display("FAIL %s: req/id/lvl %0b/%0d/%h expected %0b/%0d/%h",
                 e.tag, irq_req, irq_id, irq_lvl, e.req, e.id, e.lvl);
      end
    end
  end

  function automatic logic [31:0] w(logic p, logic en, logic [1:0] t, logic [7:0] c);
    return {16'b0, c, 4'b0, t, en, p};
  endfunction

  task automatic expect_irq(string tag, logic req, logic [2:0] id, logic [7:0] lvl);
    #1;
    q.push_back('{tag, req, id, lvl});
    @(negedge clk);
  endtask

  task automatic wr(logic [IDW:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [IDW:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s: read %h expected %h", tag, bus_rdata, exp);
    end
  endtask

  task automatic set_src(int i, logic v);
    @(negedge clk);
    src[i] = v;
    @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R2 register layout
    expect_irq("R1 no request after reset", 1'b0, 3'd0, 8'h00);
    rd("R1 config reset", 4'd0, 32'h0);
    rd("R2 info word", 4'd1, 32'h0140_0008);
    rd("R1 threshold reset", 4'd2, 32'h0);
    rd("R1 source word reset", 4'd8, 32'h0000_0F00);
    // R5 unimplemented bits read as ones
    wr(4'd11, w(1'b0, 1'b0, 2'd0, 8'hA5));
    rd("R5 control low bits ones", 4'd11, 32'h0000_AF00);
    wr(4'd0, 32'd4);
    rd("R2 config readback", 4'd0, 32'd4);
    // R3 level mode
    wr(4'd8, w(1'b1, 1'b1, 2'd0, 8'h80));
    rd("R3 pending write ignored", 4'd8, 32'h0000_8F02);
    expect_irq("R3 idle input no request", 1'b0, 3'd0, 8'h00);
    set_src(0, 1'b1);
    expect_irq("R3 level input requests", 1'b1, 3'd0, 8'h8F);
    wr(4'd8, w(1'b0, 1'b1, 2'd0, 8'h80));
    rd("R3 clear write ignored", 4'd8, 32'h0000_8F03);
    set_src(0, 1'b0);
    expect_irq("R3 pending follows low input", 1'b0, 3'd0, 8'h00);
    // R11 disabled source
    set_src(1, 1'b1);
    expect_irq("R11 disabled source not requested", 1'b0, 3'd0, 8'h00);
    rd("R11 disabled pending tracks input", 4'd9, 32'h0000_0F01);
    set_src(1, 1'b0);
    // R4 rising edge
    wr(4'd10, w(1'b0, 1'b1, 2'd1, 8'h40));
    set_src(2, 1'b1);
    expect_irq("R4 rising edge requests", 1'b1, 3'd2, 8'h4F);
    wr(4'd10, w(1'b0, 1'b1, 2'd1, 8'h40));
    expect_irq("R4 write clears edge pending", 1'b0, 3'd0, 8'h00);
    set_src(2, 1'b0);
    expect_irq("R4 falling input no rise edge", 1'b0, 3'd0, 8'h00);
    set_src(2, 1'b1);
    expect_irq("R4 second rising edge", 1'b1, 3'd2, 8'h4F);
    do_ack();
    expect_irq("R4 ack clears edge pending", 1'b0, 3'd0, 8'h00);
    rd("R4 pending zero after ack", 4'd10, 32'h0000_4F06);
    do_ret();
    expect_irq("R9 return to idle nothing pending", 1'b0, 3'd0, 8'h00);
    set_src(2, 1'b0);
    // R4 falling edge
    wr(4'd12, w(1'b0, 1'b1, 2'd2, 8'h60));
    set_src(4, 1'b1);
    expect_irq("R4 rise ignored in fall mode", 1'b0, 3'd0, 8'h00);
    set_src(4, 1'b0);
    expect_irq("R4 falling edge requests", 1'b1, 3'd4, 8'h6F);
    wr(4'd12, w(1'b0, 1'b1, 2'd2, 8'h60));
    expect_irq("R4 write clears fall pending", 1'b0, 3'd0, 8'h00);
    // R6 arbitration with two level bits, R5 split
    wr(4'd0, 32'd2);
    wr(4'd13, w(1'b0, 1'b1, 2'd0, 8'h50));
    wr(4'd14, w(1'b0, 1'b1, 2'd0, 8'h60));
    set_src(5, 1'b1);
    set_src(6, 1'b1);
    expect_irq("R6 R5 same level higher priority wins", 1'b1, 3'd6, 8'h7F);
    wr(4'd15, w(1'b0, 1'b1, 2'd0, 8'h60));
    set_src(7, 1'b1);
    expect_irq("R6 full tie highest id wins", 1'b1, 3'd7, 8'h7F);
    // R7 threshold
    wr(4'd2, 32'h7F);
    expect_irq("R7 level equal threshold masked", 1'b0, 3'd0, 8'h00);
    wr(4'd2, 32'h7E);
    expect_irq("R7 level above threshold passes", 1'b1, 3'd7, 8'h7F);
    wr(4'd2, 32'h00);
    // R8 preemption
    do_ack();
    expect_irq("R8 equal level no preemption", 1'b0, 3'd0, 8'h00);
    wr(4'd13, w(1'b0, 1'b1, 2'd0, 8'h80));
    expect_irq("R8 R6 higher level preempts", 1'b1, 3'd5, 8'hBF);
    do_ack();
    expect_irq("R9 pushed level masks others", 1'b0, 3'd0, 8'h00);
    // R10 full stack
    wr(4'd8, w(1'b0, 1'b1, 2'd0, 8'hC0));
    set_src(0, 1'b1);
    expect_irq("R10 full stack blocks request", 1'b0, 3'd0, 8'h00);
    do_ret();
    expect_irq("R9 R10 request after pop", 1'b1, 3'd0, 8'hFF);
    do_ack();
    set_src(0, 1'b0);
    do_ret();
    expect_irq("R9 tail chain to next pending", 1'b1, 3'd5, 8'hBF);
    do_ack();
    set_src(5, 1'b0);
    do_ret();
    expect_irq("R9 return to level 7F masks equal", 1'b0, 3'd0, 8'h00);
    do_ret();
    expect_irq("R9 tail chain to lower level", 1'b1, 3'd7, 8'h7F);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule